// File: doc/BRIEF.md
# Card Answer Capture with Clock Stretch

This block runs the reset sequence of a smart card. It then collects the bytes the card sends back into a receive buffer, and holds the host's I2C clock low until the card has gone quiet. A reset request pulls the card's reset line low and zero-fills the whole receive buffer through the buffer write port. It also clears the answer length and the write pointer, and asks the read side to rewind its own pointer. When both the reset hold time and the fill are complete, the reset line is released and capture is armed.

After capture is armed, every byte from the card's serial receiver is written at the next buffer address and counted in a 16-bit answer length. Two exceptions apply: bytes that arrive while a transmission to the card is still pending are not stored, and bytes beyond the end of the buffer are not written. Each stored byte asserts a clock-hold output and restarts an idle interval measured in prescaled ticks. The hold is dropped when the card has been silent for the full interval, so the host cannot read the answer length or data before the answer is complete. A one-cycle strobe tells the transmit sequencer about every byte seen once capture is armed, stored or not.

Top module: `card_answer_capture`

## Requirements
- R1: After synchronous reset, card_rst_n is 1 and scl_hold, wr_en, rx_seen, rd_rewind and answer_len are all 0.
- R2: Before the first reset request has completed, received bytes cause no buffer write, no length change, no clock hold and no rx_seen strobe.
- R3: A reset_req sampled while no sequence runs drives card_rst_n to 0 at that edge. card_rst_n stays 0 for max(RST_HOLD_TICKS*CLK_DIV, BUF_DEPTH)+1 clock cycles and then returns to 1. A reset_req that arrives during a running sequence is ignored.
- R4: During the sequence the block writes the value 0 to every buffer address from 0 to BUF_DEPTH-1 in ascending order, one per cycle, starting the cycle after the request.
- R5: On the request edge, answer_len is cleared to 0, the write pointer returns to address 0, and scl_hold is released. rd_rewind is also 1 for exactly one cycle.
- R6: Bytes received while card_rst_n is 0 are not stored.
- R7: Once armed, a byte with tx_pending low shows wr_en=1 one cycle later, with wr_data equal to the byte and wr_addr at the next address starting from 0. answer_len also increases by one at that point.
- R8: A byte received while tx_pending is 1 is not written and leaves answer_len and scl_hold unchanged.
- R9: Once armed, rx_seen is 1 for one cycle after every received byte, including bytes blocked by tx_pending.
- R10: A stored byte sets scl_hold from the next cycle. scl_hold falls exactly IDLE_TICKS*CLK_DIV cycles after the storing edge, and each further stored byte restarts the full interval.
- R11: Bytes that arrive after BUF_DEPTH bytes have been stored are not written, but each one still increments answer_len.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req | input | 1 | Request to run the card reset sequence |
| rx_valid | input | 1 | One-cycle strobe: a byte arrived from the card |
| rx_data | input | 8 | Byte received from the card |
| tx_pending | input | 1 | A transmission to the card is still outstanding |
| card_rst_n | output | 1 | Card reset line, 0 = card held in reset |
| scl_hold | output | 1 | 1 = keep the host's I2C clock pulled low |
| rx_seen | output | 1 | Strobe to the transmit sequencer for each byte seen while armed |
| rd_rewind | output | 1 | One-cycle pulse telling the read side to return to address 0 |
| wr_en | output | 1 | Receive buffer write enable |
| wr_addr | output | ADDR_W | Receive buffer write address |
| wr_data | output | 8 | Receive buffer write data |
| answer_len | output | LEN_W | Count of answer bytes since the last reset sequence |

## Verification
The properties assume that rx_valid and reset_req are synchronous to clk and already free of metastability. They also assume tx_pending is a level owned by the transmit side. The properties put no limit on how rx_valid and reset_req overlap. The directed stimulus changes inputs only at the falling edge and keeps rx_valid to single-cycle pulses, as a serial receiver delivers them. It deliberately sends a byte and a second reset request in the middle of a running sequence, and it sends bytes with tx_pending high to confirm that they are blocked.

// File: rtl/ac_pkg.sv
package ac_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic       en;
        logic [7:0] data;
    } rx_beat_t;

    typedef struct packed {
        logic       we;
        logic [7:0] data;
    } wr_beat_t;

    // Bits needed to hold the values 0..n inclusive.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ac_tick_gen.sv
module ac_tick_gen
    import ac_pkg::*;
#(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = cnt_w(DIV);

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/ac_reset_seq.sv
module ac_reset_seq
    import ac_pkg::*;
#(
    parameter int unsigned DEPTH      = 384,
    parameter int unsigned HOLD_TICKS = 65,
    parameter int          ADDR_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              tick,
    output logic              start,
    output logic              finish,
    output logic              fill_we,
    output logic [ADDR_W-1:0] fill_addr,
    output logic              card_rst_n
);
    localparam int HW = cnt_w(HOLD_TICKS);
    localparam int FW = cnt_w(DEPTH);

    seq_state_e    state;
    logic [HW-1:0] hold_cnt;
    logic [FW-1:0] fill_cnt;
    logic          hold_done;
    logic          fill_done;

    assign hold_done = (hold_cnt == HW'(HOLD_TICKS));
    assign fill_done = (fill_cnt == FW'(DEPTH));
    assign start     = (state == SEQ_IDLE) && req;
    assign finish    = (state == SEQ_RUN) && hold_done && fill_done;
    assign fill_we   = (state == SEQ_RUN) && !fill_done;
    assign fill_addr = fill_cnt[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            card_rst_n <= 1'b1;
            hold_cnt   <= '0;
            fill_cnt   <= '0;
        end else if (start) begin
            state      <= SEQ_RUN;
            card_rst_n <= 1'b0;
            hold_cnt   <= '0;
            fill_cnt   <= '0;
        end else if (finish) begin
            state      <= SEQ_IDLE;
            card_rst_n <= 1'b1;
        end else if (state == SEQ_RUN) begin
            if (tick && !hold_done) begin
                hold_cnt <= hold_cnt + HW'(1);
            end
            if (!fill_done) begin
                fill_cnt <= fill_cnt + FW'(1);
            end
        end
    end
endmodule

// File: rtl/ac_idle_timer.sv
module ac_idle_timer
    import ac_pkg::*;
#(
    parameter int unsigned IDLE_TICKS = 52
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic load,
    input  logic tick,
    output logic hold
);
    localparam int IW = cnt_w(IDLE_TICKS);

    logic [IW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            remain <= '0;
            hold   <= 1'b0;
        end else if (load) begin
            remain <= IW'(IDLE_TICKS);
            hold   <= 1'b1;
        end else if (hold && tick) begin
            if (remain == IW'(1)) begin
                remain <= '0;
                hold   <= 1'b0;
            end else begin
                remain <= remain - IW'(1);
            end
        end
    end
endmodule

// File: rtl/card_answer_capture.sv
module card_answer_capture
    import ac_pkg::*;
#(
    parameter int unsigned CLK_DIV        = 153600,
    parameter int unsigned RST_HOLD_TICKS = 65,
    parameter int unsigned IDLE_TICKS     = 52,
    parameter int unsigned BUF_DEPTH      = 384,
    parameter int          LEN_W          = 16,
    parameter int          ADDR_W         = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reset_req,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              tx_pending,
    output logic              card_rst_n,
    output logic              scl_hold,
    output logic              rx_seen,
    output logic              rd_rewind,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [LEN_W-1:0]  answer_len
);
    localparam int PTR_W = cnt_w(BUF_DEPTH);

    rx_beat_t          beat;
    wr_beat_t          wr_next;
    logic [ADDR_W-1:0] addr_next;
    logic              tick;
    logic              seq_start;
    logic              seq_finish;
    logic              fill_we;
    logic [ADDR_W-1:0] fill_addr;
    logic              armed;
    logic              store;
    logic              in_room;
    logic [PTR_W-1:0]  wr_ptr;

    assign beat    = '{en: rx_valid, data: rx_data};
    assign in_room = (wr_ptr < PTR_W'(BUF_DEPTH));
    assign store   = beat.en && armed && !tx_pending && !seq_start;

    ac_tick_gen #(.DIV(CLK_DIV)) tick_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (seq_start || store),
        .tick (tick)
    );

    ac_reset_seq #(
        .DEPTH      (BUF_DEPTH),
        .HOLD_TICKS (RST_HOLD_TICKS),
        .ADDR_W     (ADDR_W)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .req        (reset_req),
        .tick       (tick),
        .start      (seq_start),
        .finish     (seq_finish),
        .fill_we    (fill_we),
        .fill_addr  (fill_addr),
        .card_rst_n (card_rst_n)
    );

    ac_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) idle_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (seq_start),
        .load (store),
        .tick (tick),
        .hold (scl_hold)
    );

    // Zero fill and capture never overlap: capture is disarmed while filling.
    always_comb begin
        if (fill_we) begin
            wr_next   = '{we: 1'b1, data: 8'h00};
            addr_next = fill_addr;
        end else begin
            wr_next   = '{we: store && in_room, data: beat.data};
            addr_next = wr_ptr[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            wr_ptr     <= '0;
            answer_len <= '0;
            rd_rewind  <= 1'b0;
            rx_seen    <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            wr_en     <= wr_next.we;
            wr_addr   <= addr_next;
            wr_data   <= wr_next.data;
            rx_seen   <= beat.en && armed && !seq_start;
            rd_rewind <= seq_start;
            if (seq_start) begin
                armed      <= 1'b0;
                wr_ptr     <= '0;
                answer_len <= '0;
            end else begin
                if (seq_finish) begin
                    armed <= 1'b1;
                end
                if (store) begin
                    answer_len <= answer_len + LEN_W'(1);
                    if (in_room) begin
                        wr_ptr <= wr_ptr + PTR_W'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/card_answer_capture_chk.sv
module card_answer_capture_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             reset_req,
    input logic             rx_valid,
    input logic             tx_pending,
    input logic             card_rst_n,
    input logic             scl_hold,
    input logic             rx_seen,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic [LEN_W-1:0] answer_len
);
    assert_rst_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(card_rst_n) |-> $past(reset_req));

    assert_fill_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (!card_rst_n && wr_en) |-> (wr_data == 8'h00));

    assert_len_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(card_rst_n) |-> (answer_len == '0));

    assert_len_step_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && card_rst_n) |-> (answer_len == $past(answer_len) + LEN_W'(1)));

    assert_pending_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && tx_pending && card_rst_n) |=> !wr_en);

    assert_seen_cause_R9: assert property (@(posedge clk) disable iff (rst)
        rx_seen |-> $past(rx_valid));

    assert_hold_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_hold) |-> $past(rx_valid && !tx_pending && card_rst_n));
endmodule

bind card_answer_capture card_answer_capture_chk #(.LEN_W(LEN_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .reset_req  (reset_req),
    .rx_valid   (rx_valid),
    .tx_pending (tx_pending),
    .card_rst_n (card_rst_n),
    .scl_hold   (scl_hold),
    .rx_seen    (rx_seen),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .answer_len (answer_len)
);

// File: tb/card_answer_capture_tb_top.sv
`timescale 1ns/1ps
module card_answer_capture_tb_top;
    localparam int DIV   = 4;
    localparam int RHOLD = 8;
    localparam int IDLE  = 5;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int SEQ_LOW  = ((RHOLD * DIV > DEPTH) ? RHOLD * DIV : DEPTH) + 1;
    localparam int HOLD_CYC = IDLE * DIV;

    logic          clk = 1'b0;
    logic          rst;
    logic          reset_req;
    logic          rx_valid;
    logic [7:0]    rx_data;
    logic          tx_pending;
    logic          card_rst_n;
    logic          scl_hold;
    logic          rx_seen;
    logic          rd_rewind;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [15:0]   answer_len;

    int n_checks = 0;
    int n_fail   = 0;
    int log_n    = 0;
    logic [AW-1:0] log_addr [0:63];
    logic [7:0]    log_data [0:63];

    always #2.5 clk = ~clk;

    card_answer_capture #(
        .CLK_DIV(DIV), .RST_HOLD_TICKS(RHOLD), .IDLE_TICKS(IDLE),
        .BUF_DEPTH(DEPTH), .LEN_W(16)
    ) dut_i (
        .clk(clk), .rst(rst), .reset_req(reset_req), .rx_valid(rx_valid),
        .rx_data(rx_data), .tx_pending(tx_pending), .card_rst_n(card_rst_n),
        .scl_hold(scl_hold), .rx_seen(rx_seen), .rd_rewind(rd_rewind),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .answer_len(answer_len)
    );

    // Write monitor, sampling 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (wr_en && log_n < 64) begin
            log_addr[log_n] = wr_addr;
            log_data[log_n] = wr_data;
            log_n = log_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drives one byte for one edge; returns at the negedge after the storing edge.
    task automatic send(input logic [7:0] d);
        rx_valid = 1'b1;
        rx_data  = d;
        step();
        rx_valid = 1'b0;
    endtask

    task automatic t_reset_state;
        check("R1 card_rst_n", card_rst_n, 1);
        check("R1 scl_hold", scl_hold, 0);
        check("R1 wr_en", wr_en, 0);
        check("R1 answer_len", answer_len, 0);
        check("R1 rx_seen", rx_seen, 0);
        check("R1 rd_rewind", rd_rewind, 0);
    endtask

    task automatic t_pre_capture;
        int base = log_n;
        send(8'hA5);
        check("R2 rx_seen", rx_seen, 0);
        check("R2 scl_hold", scl_hold, 0);
        step();
        check("R2 answer_len", answer_len, 0);
        check("R2 no write", log_n - base, 0);
    endtask

    task automatic t_reset_seq;
        int base = log_n;
        logic low_ok = 1'b1;
        logic data_ok = 1'b1;
        reset_req = 1'b1;
        step();
        reset_req = 1'b0;
        check("R3 reset low at request", card_rst_n, 0);
        check("R5 rewind pulse", rd_rewind, 1);
        check("R5 length cleared", answer_len, 0);
        for (int i = 2; i <= SEQ_LOW; i++) begin
            if (i == 3) begin
                // R6: byte during reset; R3: second request ignored
                rx_valid = 1'b1; rx_data = 8'h5C; reset_req = 1'b1;
            end
            step();
            rx_valid = 1'b0; reset_req = 1'b0;
            if (card_rst_n !== 1'b0) low_ok = 1'b0;
            if (i == 2) check("R5 rewind one cycle", rd_rewind, 0);
            if (i == 3) check("R6 no rx_seen in reset", rx_seen, 0);
        end
        check("R3 held low full interval", low_ok, 1);
        step();
        check("R3 released after interval", card_rst_n, 1);
        check("R4 fill write count", log_n - base, DEPTH);
        for (int k = 0; k < DEPTH; k++) begin
            if (log_addr[base + k] !== AW'(k) || log_data[base + k] !== 8'h00) data_ok = 1'b0;
        end
        check("R4 R6 ascending zero fill", data_ok, 1);
    endtask

    task automatic t_store;
        logic [7:0] vals [0:2] = '{8'h11, 8'h22, 8'h33};
        for (int k = 0; k < 3; k++) begin
            send(vals[k]);
            check("R7 wr_en", wr_en, 1);
            check("R7 wr_addr", wr_addr, k);
            check("R7 wr_data", wr_data, vals[k]);
            check("R7 answer_len", answer_len, k + 1);
            check("R9 rx_seen", rx_seen, 1);
            check("R10 hold set", scl_hold, 1);
            if (k < 2) step(2);
        end
        step(HOLD_CYC - 1);
        check("R10 hold until interval end", scl_hold, 1);
        step();
        check("R10 hold released", scl_hold, 0);
    endtask

    task automatic t_restart;
        send(8'h44);
        step(10);
        send(8'h55);
        check("R7 next addr", wr_addr, 4);
        step(HOLD_CYC - 1);
        check("R10 restarted hold", scl_hold, 1);
        step();
        check("R10 restarted release", scl_hold, 0);
    endtask

    task automatic t_pending;
        tx_pending = 1'b1;
        send(8'h77);
        tx_pending = 1'b0;
        check("R8 no write", wr_en, 0);
        check("R8 len unchanged", answer_len, 5);
        check("R8 hold untouched", scl_hold, 0);
        check("R9 seen while pending", rx_seen, 1);
        step();
        check("R9 one cycle", rx_seen, 0);
    endtask

    task automatic t_overflow;
        for (int k = 5; k < DEPTH; k++) send(8'h80 + 8'(k));
        check("R7 last addr", wr_addr, DEPTH - 1);
        send(8'hEE);
        check("R11 no write past end", wr_en, 0);
        check("R11 length still counts", answer_len, DEPTH + 1);
    endtask

    task automatic t_second_reset;
        reset_req = 1'b1;
        step();
        reset_req = 1'b0;
        check("R5 length cleared again", answer_len, 0);
        check("R5 hold released", scl_hold, 0);
        check("R5 rewind again", rd_rewind, 1);
        step(SEQ_LOW);
        check("R3 second release", card_rst_n, 1);
        send(8'h9A);
        check("R5 pointer back to 0", wr_addr, 0);
        check("R5 R7 first data", wr_data, 8'h9A);
        check("R7 length 1", answer_len, 1);
    endtask

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; reset_req = 1'b0; rx_valid = 1'b0; rx_data = '0; tx_pending = 1'b0;
        step(3);
        rst = 1'b0;
        step();
        t_reset_state();
        t_pre_capture();
        t_reset_seq();
        t_store();
        t_restart();
        t_pending();
        t_overflow();
        t_second_reset();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule